// File: doc/BRIEF.md
# Legacy PC System Control Port

This block is a small piece of I/O-mapped glue for a PC-style system. It has two functions. The first is the address-line-20 gate: software writes a byte to the gate port and the block drives the gate output from one bit of that byte. The second is the numeric-coprocessor error interrupt: a rising edge on the floating-point error input raises a level interrupt request, and any byte written to the clear port drops it again. A write to the POST delay port is accepted with no effect. The block has no other registers.

The bus is a simple one. An address, a write strobe, a read strobe and a write byte are sampled on the rising clock edge. The read byte is combinational from the current address and state. Only the gate port can be read. Every other read returns all ones. Port addresses are parameters, and their defaults are the classic PC locations: 0x92 for the gate port, 0xF0 for the error clear and 0x80 for the delay port.

Top module: `sysctl_port`

## Requirements
- R1: While reset is asserted, and on the first cycle after it, the gate output and the interrupt request are both 0.
- R2: A write to the gate port (default 0x92) sets the gate output, on the next clock edge, to bit 1 of the written byte.
- R3: While a read of the gate port is in progress, the read byte is 0x02 when the gate output is 1 and 0x00 when it is 0. Only bit 1 carries the state.
- R4: Bit 0 and bits 7..2 of a gate-port write have no effect. The gate output follows bit 1 alone, and a readback shows bit 0 as 0.
- R5: A rising edge on the error input (low on one clock edge, high on the next) sets the interrupt request to 1 on that edge.
- R6: A write to the clear port (default 0xF0) drops the interrupt request to 0 on the next edge, whatever the data byte.
- R7: When a rising edge of the error input and a clear-port write fall on the same edge, the interrupt request is 1.
- R8: An error input that stays high does not set the request again after a clear. A level held high through reset does not count as an edge.
- R9: A write to the delay port (default 0x80) changes neither the gate output nor the interrupt request.
- R10: A read of any address other than the gate port returns 0xFF and changes no state. The read byte is also 0xFF when no read is in progress.
- R11: A write to an address that is not decoded has no effect on either output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| io_addr | input | ADDR_W (16) | I/O address |
| io_wr | input | 1 | Write strobe, one cycle per access |
| io_rd | input | 1 | Read strobe |
| io_wdata | input | 8 | Write byte |
| io_rdata | output | 8 | Read byte (combinational) |
| fpu_err_in | input | 1 | Floating-point error level from the CPU |
| gate_a20 | output | 1 | Address-line-20 gate enable |
| irq_fpu | output | 1 | Coprocessor error interrupt request (level) |

## Verification
The assertions check the following on every cycle:
- the gate output follows bit 1 of each gate-port write and holds its value otherwise;
- the read byte takes the gate-readback or all-ones form;
- a rising edge of the error input raises the request;
- the request stays steady when there is no edge and no clear.

Some behaviours depend on the history of the error line, and only the bench's scenarios can show them. These are:
- the clear losing to a simultaneous edge;
- a level held high across a clear or across reset;
- random data patterns on the ignored bits and on the delay port.

// File: rtl/sysctl_pkg.sv
package sysctl_pkg;

    // Bit of the gate-port byte that carries the A20 enable
    localparam int unsigned A20_BIT  = 1;
    localparam logic [7:0]  A20_MASK = 8'(1 << A20_BIT);
    localparam logic [7:0]  RD_OPEN  = 8'hFF;

    typedef struct packed {
        logic gate_wr;
        logic gate_rd;
        logic errclr_wr;
    } io_hit_t;

    typedef struct packed {
        logic rise;
        logic clear;
    } irq_evt_t;

    function automatic logic [7:0] gate_readback(input logic en);
        return en ? A20_MASK : 8'h00;
    endfunction

endpackage

// File: rtl/sysctl_io_decode.sv
module sysctl_io_decode
    import sysctl_pkg::*;
#(
    parameter int unsigned     ADDR_W      = 16,
    parameter logic [ADDR_W-1:0] GATE_ADDR   = 'h92,
    parameter logic [ADDR_W-1:0] ERRCLR_ADDR = 'hF0
) (
    input  logic [ADDR_W-1:0] io_addr,
    input  logic              io_wr,
    input  logic              io_rd,
    output io_hit_t           hit
);
    logic at_gate;
    logic at_clr;

    always_comb begin
        at_gate       = (io_addr == GATE_ADDR);
        at_clr        = (io_addr == ERRCLR_ADDR);
        hit.gate_wr   = io_wr & at_gate;
        hit.gate_rd   = io_rd & at_gate;
        hit.errclr_wr = io_wr & at_clr;
    end
endmodule

// File: rtl/sysctl_a20_reg.sv
module sysctl_a20_reg
    import sysctl_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       wr_en,
    input  logic [7:0] wdata,
    output logic       a20_en
);
    logic a20_d;

    always_comb a20_d = |(wdata & A20_MASK);

    always_ff @(posedge clk) begin
        if (rst)
            a20_en <= 1'b0;
        else if (wr_en)
            a20_en <= a20_d;
    end
endmodule

// File: rtl/sysctl_ferr_latch.sv
module sysctl_ferr_latch
    import sysctl_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic ferr,
    input  logic clr_wr,
    output logic irq
);
    logic     ferr_q;
    irq_evt_t evt;

    // ferr_q follows the input even during reset, so a level held
    // through reset is not seen as an edge.
    always_ff @(posedge clk) ferr_q <= ferr;

    always_comb begin
        evt.rise  = ferr & ~ferr_q;
        evt.clear = clr_wr;
    end

    always_ff @(posedge clk) begin
        if (rst)
            irq <= 1'b0;
        else if (evt.rise)
            irq <= 1'b1;
        else if (evt.clear)
            irq <= 1'b0;
    end
endmodule

// File: rtl/sysctl_port.sv
module sysctl_port
    import sysctl_pkg::*;
#(
    parameter int unsigned       ADDR_W      = 16,
    parameter logic [ADDR_W-1:0] GATE_ADDR   = 'h92,
    parameter logic [ADDR_W-1:0] ERRCLR_ADDR = 'hF0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] io_addr,
    input  logic              io_wr,
    input  logic              io_rd,
    input  logic [7:0]        io_wdata,
    output logic [7:0]        io_rdata,
    input  logic              fpu_err_in,
    output logic              gate_a20,
    output logic              irq_fpu
);
    io_hit_t hit;

    sysctl_io_decode #(
        .ADDR_W     (ADDR_W),
        .GATE_ADDR  (GATE_ADDR),
        .ERRCLR_ADDR(ERRCLR_ADDR)
    ) u_dec (
        .io_addr(io_addr),
        .io_wr  (io_wr),
        .io_rd  (io_rd),
        .hit    (hit)
    );

    sysctl_a20_reg u_a20 (
        .clk   (clk),
        .rst   (rst),
        .wr_en (hit.gate_wr),
        .wdata (io_wdata),
        .a20_en(gate_a20)
    );

    sysctl_ferr_latch u_ferr (
        .clk   (clk),
        .rst   (rst),
        .ferr  (fpu_err_in),
        .clr_wr(hit.errclr_wr),
        .irq   (irq_fpu)
    );

    always_comb io_rdata = hit.gate_rd ? gate_readback(gate_a20) : RD_OPEN;
endmodule

// File: rtl/sysctl_port_chk.sv
module sysctl_port_chk #(
    parameter int unsigned       ADDR_W      = 16,
    parameter logic [ADDR_W-1:0] GATE_ADDR   = 'h92,
    parameter logic [ADDR_W-1:0] ERRCLR_ADDR = 'hF0
) (
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] io_addr,
    input logic              io_wr,
    input logic              io_rd,
    input logic [7:0]        io_wdata,
    input logic [7:0]        io_rdata,
    input logic              fpu_err_in,
    input logic              gate_a20,
    input logic              irq_fpu
);
    logic gate_w, clr_w;
    assign gate_w = io_wr && (io_addr == GATE_ADDR);
    assign clr_w  = io_wr && (io_addr == ERRCLR_ADDR);

    AST_RESET_CLEAR: assert property (@(posedge clk)
        rst |=> (!gate_a20 && !irq_fpu)); // R1

    AST_GATE_FOLLOWS_BIT1: assert property (@(posedge clk) disable iff (rst)
        gate_w |=> (gate_a20 == $past(io_wdata[1]))); // R2

    AST_GATE_HOLDS: assert property (@(posedge clk) disable iff (rst)
        !gate_w |=> $stable(gate_a20)); // R11

    AST_GATE_READBACK: assert property (@(posedge clk) disable iff (rst)
        (io_rd && io_addr == GATE_ADDR) |-> (io_rdata[1] == gate_a20 && io_rdata[7:2] == 6'd0 && !io_rdata[0])); // R3

    AST_OPEN_READ: assert property (@(posedge clk) disable iff (rst)
        !(io_rd && io_addr == GATE_ADDR) |-> (io_rdata == 8'hFF)); // R10

    AST_EDGE_SETS_IRQ: assert property (@(posedge clk) disable iff (rst)
        $rose(fpu_err_in) |-> ##0 1'b1 ##1 irq_fpu); // R5

    AST_CLEAR_DROPS_IRQ: assert property (@(posedge clk) disable iff (rst)
        (clr_w && !(fpu_err_in && !$past(fpu_err_in))) |=> !irq_fpu); // R6

    AST_IRQ_STEADY: assert property (@(posedge clk) disable iff (rst)
        (!clr_w && !(fpu_err_in && !$past(fpu_err_in))) |=> $stable(irq_fpu)); // R9
endmodule

bind sysctl_port sysctl_port_chk #(
    .ADDR_W     (ADDR_W),
    .GATE_ADDR  (GATE_ADDR),
    .ERRCLR_ADDR(ERRCLR_ADDR)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .io_addr   (io_addr),
    .io_wr     (io_wr),
    .io_rd     (io_rd),
    .io_wdata  (io_wdata),
    .io_rdata  (io_rdata),
    .fpu_err_in(fpu_err_in),
    .gate_a20  (gate_a20),
    .irq_fpu   (irq_fpu)
);

// File: tb/tb_sysctl_port.sv
module tb_sysctl_port;
    localparam int CLK_PERIOD = 10;
    localparam logic [15:0] P_GATE  = 16'h0092;
    localparam logic [15:0] P_CLR   = 16'h00F0;
    localparam logic [15:0] P_DELAY = 16'h0080;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] io_addr = '0;
    logic        io_wr = 1'b0;
    logic        io_rd = 1'b0;
    logic [7:0]  io_wdata = '0;
    logic [7:0]  io_rdata;
    logic        fpu_err_in = 1'b0;
    logic        gate_a20;
    logic        irq_fpu;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit done   = 1'b0;

    logic exp_a20 = 1'b0;
    logic exp_irq = 1'b0;
    logic prev_ferr = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sysctl_port dut (
        .clk(clk), .rst(rst), .io_addr(io_addr), .io_wr(io_wr), .io_rd(io_rd),
        .io_wdata(io_wdata), .io_rdata(io_rdata), .fpu_err_in(fpu_err_in),
        .gate_a20(gate_a20), .irq_fpu(irq_fpu)
    );

    function automatic logic [7:0] exp_read(input logic rd, input logic [15:0] a, input logic en);
        if (rd && a == P_GATE) return en ? 8'h02 : 8'h00;
        return 8'hFF;
    endfunction

    function automatic logic next_irq(input logic rise, input logic clr, input logic cur);
        if (rise) return 1'b1;
        if (clr)  return 1'b0;
        return cur;
    endfunction

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%02h expected=%02h at cycle %0d", tag, act, exp, cycles);
        end
    endtask

    // One bus cycle: drive at negedge, check read byte, clock, check state.
    task automatic step(input logic wr, input logic rd, input logic [15:0] a,
                        input logic [7:0] d, input logic ferr, input string tag);
        @(negedge clk);
        io_wr = wr; io_rd = rd; io_addr = a; io_wdata = d; fpu_err_in = ferr;
        #1;
        check((rd && a == P_GATE) ? "R3 read" : "R10 read", io_rdata, exp_read(rd, a, exp_a20));
        @(posedge clk);
        if (rst) begin
            exp_a20 = 1'b0;
            exp_irq = 1'b0;
        end else begin
            if (wr && a == P_GATE) exp_a20 = d[1];
            exp_irq = next_irq(ferr && !prev_ferr, wr && a == P_CLR, exp_irq);
        end
        prev_ferr = ferr;
        #1;
        check({tag, " a20"}, {7'd0, gate_a20}, {7'd0, exp_a20});
        check({tag, " irq"}, {7'd0, irq_fpu}, {7'd0, exp_irq});
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000 && !done) begin
            done = 1'b1;
            errors++; checks++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        // Reset with the error line held high: not an edge afterwards (R8)
        step(0, 0, 0, 0, 1, "R1 in reset");
        step(1, 0, P_GATE, 8'hFF, 1, "R1 in reset");
        rst = 1'b0;
        step(0, 0, 0, 0, 1, "R1 after reset");
        step(0, 0, 0, 0, 1, "R8 level across reset");
        step(0, 0, 0, 0, 0, "R8 release");

        // Gate register and ignored bits
        step(1, 0, P_GATE, 8'h02, 0, "R2 set");
        step(0, 1, P_GATE, 8'h00, 0, "R3 readback one");
        step(1, 0, P_GATE, 8'hFD, 0, "R4 other bits high");
        step(0, 1, P_GATE, 8'h00, 0, "R3 readback zero");
        step(1, 0, P_GATE, 8'h03, 0, "R4 bit0 set");
        step(0, 1, P_GATE, 8'h00, 0, "R4 bit0 reads zero");
        step(1, 0, 16'h0093, 8'h00, 0, "R11 neighbour write");
        step(1, 0, 16'h0192, 8'h00, 0, "R11 high-byte alias");

        // Interrupt latch
        step(0, 0, 0, 0, 1, "R5 edge");
        step(1, 0, P_DELAY, 8'hA5, 1, "R9 delay port");
        step(1, 0, P_CLR, 8'h00, 1, "R6 clear held");
        step(0, 0, 0, 0, 1, "R8 held no reset");
        step(0, 0, 0, 0, 1, "R8 held no reset");
        step(0, 0, 0, 0, 0, "R8 low");
        step(1, 0, P_CLR, 8'h5A, 1, "R7 edge with clear");
        step(1, 0, P_CLR, 8'hFF, 1, "R6 clear any data");
        step(0, 1, P_CLR, 8'h00, 0, "R10 read clear port");
        step(0, 1, P_DELAY, 8'h00, 0, "R10 read delay port");
        step(0, 1, 16'h0070, 8'h00, 0, "R10 read unmapped");

        // Constrained random
        for (int i = 0; i < 400; i++) begin
            logic [15:0] a;
            int sel = $urandom_range(0, 4);
            case (sel)
                0: a = P_GATE;
                1: a = P_CLR;
                2: a = P_DELAY;
                default: a = 16'($urandom);
            endcase
            step($urandom_range(0, 1) == 1, $urandom_range(0, 1) == 1, a,
                 8'($urandom), ($urandom_range(0, 3) == 0) ? ~prev_ferr : prev_ferr,
                 "R2 R5 R6 random");
        end

        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule